// File: doc/BRIEF.md
# Channel Code Loader and Divide-Ratio Lookup

This block holds the selected channel of a two-loop radio frequency synthesizer and turns it into the divide ratios for the receive and transmit loop counters. A host can supply the 4-bit channel code in two ways. It can clock the code in one bit at a time on a slow serial interface, with a serial clock, a data line and a load strobe. It can also present the code in parallel on four wires.

In serial operation, each serial clock edge shifts in one bit. Nothing changes at the outputs until the load strobe rises. At that point the shifted code is copied into the holding latch, so the channel in use stays put while a new one is being shifted in. All three serial lines are asynchronous to the system clock. They are synchronised, and their rising edges are detected on the system clock.

The latched code and a base/remote station input together select one of 32 lookup words. Each word carries a 14-bit receive ratio and a 14-bit transmit ratio. Codes that name no channel fall back to channel 10. Both ratios leave the block through registers.

Top module: `chan_ratio_ctrl`

## Requirements
- R1: Each synchronised rising edge of `ser_clk` shifts the synchronised `ser_data` into the 4-bit shift register. The first bit shifted in ends up as the most significant code bit, and the fourth bit as the least significant.
- R2: The holding latch takes the shift register contents only on a synchronised rising edge of `ser_load` while `par_sel` is 0. Shifting alone leaves both ratio outputs unchanged.
- R3: With `base_mode`=1, codes 1 to 10 give receive ratios 7795, 7830, 7833, 7815, 7836, 7827, 7839, 7847, 7859, 7855 and transmit ratios 9322, 9326, 9334, 9342, 9346, 9354, 9366, 9374, 9386, 9394, in that channel order.
- R4: With `base_mode`=0, codes 1 to 10 give receive ratios 7183, 7187, 7195, 7203, 7207, 7215, 7227, 7235, 7247, 7255 and transmit ratios 9934, 9969, 9972, 9954, 9975, 9966, 9978, 9986, 9998, 9994.
- R5: Codes 0 and 11 to 15 give the channel 10 ratios of the current mode.
- R6: After reset the latch holds code 0, so the outputs show the channel 10 ratios for the applied mode.
- R7: While `par_sel` is 1, the latch follows `par_code` (bit 0 is the least significant) on every clock, and serial loads have no effect.
- R8: The ratio outputs are registered. They change only on the clock after a load event, after a cycle with `par_sel` high, or after a change of `base_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_mode | input | 1 | 1 = base station table, 0 = remote table |
| par_sel | input | 1 | 1 = take the code from `par_code` |
| par_code | input | 4 | Parallel channel code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Serial load strobe; its rising edge latches the code |
| rx_ratio | output | 14 | Receive loop divide ratio |
| tx_ratio | output | 14 | Transmit loop divide ratio |

## Verification
The bench shifts codes whose bit-reversed forms name different channels, such as 0001 against 1000. A design that shifted in the wrong order would then return a plainly wrong channel. It samples the outputs after shifting but before the load strobe, which catches a design that lets the shift register reach the lookup directly. It walks every legal code in both modes and every illegal code, so a swapped table entry or a mistaken fallback channel shows up as a wrong ratio. It also fires serial loads while parallel selection is active, to expose a latch that the strobe can still overwrite.

// File: rtl/chan_ratio_pkg.sv
package chan_ratio_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 14;
  localparam int WORD_W  = 2 * RATIO_W;
  localparam int NUM_CH  = 10;
  localparam logic [CODE_W-1:0] DEFAULT_CH = CODE_W'(NUM_CH);

  // Map a raw code onto a legal channel number 1..NUM_CH.
  function automatic logic [CODE_W-1:0] legal_ch(input logic [CODE_W-1:0] code);
    if (code == '0 || code > DEFAULT_CH) return DEFAULT_CH;
    return code;
  endfunction

  function automatic logic [RATIO_W-1:0] rx_of(input logic base, input logic [CODE_W-1:0] ch);
    logic [RATIO_W-1:0] r;
    if (base) begin
      case (ch)
        4'd1: r = 14'd7795;  4'd2: r = 14'd7830;  4'd3: r = 14'd7833;
        4'd4: r = 14'd7815;  4'd5: r = 14'd7836;  4'd6: r = 14'd7827;
        4'd7: r = 14'd7839;  4'd8: r = 14'd7847;  4'd9: r = 14'd7859;
        default: r = 14'd7855;
      endcase
    end else begin
      case (ch)
        4'd1: r = 14'd7183;  4'd2: r = 14'd7187;  4'd3: r = 14'd7195;
        4'd4: r = 14'd7203;  4'd5: r = 14'd7207;  4'd6: r = 14'd7215;
        4'd7: r = 14'd7227;  4'd8: r = 14'd7235;  4'd9: r = 14'd7247;
        default: r = 14'd7255;
      endcase
    end
    return r;
  endfunction

  function automatic logic [RATIO_W-1:0] tx_of(input logic base, input logic [CODE_W-1:0] ch);
    logic [RATIO_W-1:0] r;
    if (base) begin
      case (ch)
        4'd1: r = 14'd9322;  4'd2: r = 14'd9326;  4'd3: r = 14'd9334;
        4'd4: r = 14'd9342;  4'd5: r = 14'd9346;  4'd6: r = 14'd9354;
        4'd7: r = 14'd9366;  4'd8: r = 14'd9374;  4'd9: r = 14'd9386;
        default: r = 14'd9394;
      endcase
    end else begin
      case (ch)
        4'd1: r = 14'd9934;  4'd2: r = 14'd9969;  4'd3: r = 14'd9972;
        4'd4: r = 14'd9954;  4'd5: r = 14'd9975;  4'd6: r = 14'd9966;
        4'd7: r = 14'd9978;  4'd8: r = 14'd9986;  4'd9: r = 14'd9998;
        default: r = 14'd9994;
      endcase
    end
    return r;
  endfunction

  // Packed lookup word: receive ratio in the upper half, transmit in the lower.
  function automatic logic [WORD_W-1:0] ratio_word(input logic base, input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] ch;
    ch = legal_ch(code);
    return {rx_of(base, ch), tx_of(base, ch)};
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/code_latch.sv
module code_latch
  import chan_ratio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              load_en,
  input  logic              par_sel,
  input  logic [CODE_W-1:0] par_code,
  output logic [CODE_W-1:0] latch_q,
  output logic [CODE_W-1:0] latch_nxt
);
  logic [CODE_W-1:0] shreg_q, shreg_nxt;

  always_comb begin
    shreg_nxt = shreg_q;
    if (shift_en) shreg_nxt = {shreg_q[CODE_W-2:0], bit_in};
  end

  always_comb begin
    latch_nxt = latch_q;
    if (par_sel)      latch_nxt = par_code;
    else if (load_en) latch_nxt = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      latch_q <= '0;
    end else begin
      shreg_q <= shreg_nxt;
      latch_q <= latch_nxt;
    end
  end

  assert_shift_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shreg_q == {$past(shreg_q[CODE_W-2:0]), $past(bit_in)});

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !par_sel) |=> $stable(latch_q));

  assert_par_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_sel |=> latch_q == $past(par_code));
endmodule

// File: rtl/ratio_lookup.sv
module ratio_lookup
  import chan_ratio_pkg::*;
(
  input  logic               base,
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] rx,
  output logic [RATIO_W-1:0] tx
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word = ratio_word(base, code);
    rx   = word[WORD_W-1:RATIO_W];
    tx   = word[RATIO_W-1:0];
  end
endmodule

// File: rtl/chan_ratio_ctrl.sv
module chan_ratio_ctrl
  import chan_ratio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_mode,
  input  logic               par_sel,
  input  logic [CODE_W-1:0]  par_code,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_load,
  output logic [RATIO_W-1:0] rx_ratio,
  output logic [RATIO_W-1:0] tx_ratio
);
  localparam logic [WORD_W-1:0] RESET_WORD = ratio_word(1'b1, '0);

  logic sclk_s, sdat_s, sld_s;
  logic sclk_prev, sld_prev;
  logic shift_pulse, load_pulse;
  logic mode_q;
  logic [CODE_W-1:0] latch_q, latch_nxt;
  logic [RATIO_W-1:0] rx_nxt, tx_nxt;

  bit_sync #(.STAGES(SYNC_STAGES)) u_sync_clk  (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sclk_s));
  bit_sync #(.STAGES(SYNC_STAGES)) u_sync_data (.clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));
  bit_sync #(.STAGES(SYNC_STAGES)) u_sync_load (.clk(clk), .rst_n(rst_n), .d(ser_load), .q(sld_s));

  assign shift_pulse = sclk_s & ~sclk_prev;
  assign load_pulse  = sld_s & ~sld_prev;

  code_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_pulse), .bit_in(sdat_s),
    .load_en(load_pulse), .par_sel(par_sel), .par_code(par_code),
    .latch_q(latch_q), .latch_nxt(latch_nxt)
  );

  ratio_lookup u_lookup (
    .base(base_mode), .code(latch_nxt), .rx(rx_nxt), .tx(tx_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sld_prev  <= 1'b0;
      mode_q    <= 1'b1;
      rx_ratio  <= RESET_WORD[WORD_W-1:RATIO_W];
      tx_ratio  <= RESET_WORD[RATIO_W-1:0];
    end else begin
      sclk_prev <= sclk_s;
      sld_prev  <= sld_s;
      mode_q    <= base_mode;
      rx_ratio  <= rx_nxt;
      tx_ratio  <= tx_nxt;
    end
  end

  // R8: without a load, parallel cycle or mode change, the outputs hold.
  assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pulse && !par_sel && base_mode == mode_q) |=> ($stable(rx_ratio) && $stable(tx_ratio)));

  assert_rx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ratio >= 14'd7183 && rx_ratio <= 14'd7859);

  assert_tx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ratio >= 14'd9322 && tx_ratio <= 14'd9998);

  // R5: a latched illegal code reads back as channel 10 of the mode in use.
  assert_illegal_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pulse && !par_sel && base_mode == mode_q && (latch_q == '0 || latch_q > 4'd10))
      |=> (rx_ratio == (mode_q ? 14'd7855 : 14'd7255)));
endmodule

// File: tb/chan_ratio_ctrl_bench.sv
module chan_ratio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n, base_mode, par_sel, ser_clk, ser_data, ser_load;
  logic [3:0]  par_code;
  logic [13:0] rx_ratio, tx_ratio;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  chan_ratio_ctrl u_chan_ratio_ctrl (
    .clk(clk), .rst_n(rst_n), .base_mode(base_mode), .par_sel(par_sel),
    .par_code(par_code), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .rx_ratio(rx_ratio), .tx_ratio(tx_ratio)
  );

  function automatic int exp_rx(input bit base, input int code);
    int ch;
    int b[10] = '{7795, 7830, 7833, 7815, 7836, 7827, 7839, 7847, 7859, 7855};
    int r[10] = '{7183, 7187, 7195, 7203, 7207, 7215, 7227, 7235, 7247, 7255};
    ch = (code >= 1 && code <= 10) ? code : 10;
    return base ? b[ch-1] : r[ch-1];
  endfunction

  function automatic int exp_tx(input bit base, input int code);
    int ch;
    int b[10] = '{9322, 9326, 9334, 9342, 9346, 9354, 9366, 9374, 9386, 9394};
    int r[10] = '{9934, 9969, 9972, 9954, 9975, 9966, 9978, 9986, 9998, 9994};
    ch = (code >= 1 && code <= 10) ? code : 10;
    return base ? b[ch-1] : r[ch-1];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input bit base, input int code);
    check(req, rx_ratio, exp_rx(base, code));
    check(req, tx_ratio, exp_tx(base, code));
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_code(input logic [3:0] code);
    for (int i = 3; i >= 0; i--) begin
      ser_data = code[i];
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(4);
    end
  endtask

  task automatic strobe_load();
    ser_load = 1'b1;
    wait_cyc(4);
    ser_load = 1'b0;
    wait_cyc(4);
  endtask

  // R6: state right after reset
  task automatic t_reset();
    wait_cyc(1);
    check_pair("R6 reset base", 1'b1, 0);
    base_mode = 1'b0;
    wait_cyc(2);
    check_pair("R6 reset remote", 1'b0, 0);
    base_mode = 1'b1;
    wait_cyc(2);
  endtask

  // R1/R2: order of bits and hold until the strobe
  task automatic t_serial_order();
    shift_code(4'b0001);
    check_pair("R2 hold before load", 1'b1, 0);
    strobe_load();
    check_pair("R1 code 0001", 1'b1, 1);
    shift_code(4'b1000);
    check_pair("R2 hold while shifting", 1'b1, 1);
    strobe_load();
    check_pair("R1 code 1000", 1'b1, 8);
    shift_code(4'b0110);
    strobe_load();
    check_pair("R1 code 0110", 1'b1, 6);
  endtask

  task automatic t_base_table();
    base_mode = 1'b1;
    for (int c = 1; c <= 10; c++) begin
      shift_code(4'(c));
      strobe_load();
      check_pair("R3 base table", 1'b1, c);
    end
  endtask

  task automatic t_remote_table();
    base_mode = 1'b0;
    wait_cyc(2);
    for (int c = 1; c <= 10; c++) begin
      shift_code(4'(c));
      strobe_load();
      check_pair("R4 remote table", 1'b0, c);
    end
  endtask

  task automatic t_illegal();
    for (int m = 0; m < 2; m++) begin
      base_mode = m[0];
      shift_code(4'd3);
      strobe_load();
      shift_code(4'd0);
      strobe_load();
      check_pair("R5 code 0", m[0], 0);
      for (int c = 11; c <= 15; c++) begin
        shift_code(4'd3);
        strobe_load();
        shift_code(4'(c));
        strobe_load();
        check_pair("R5 illegal code", m[0], c);
      end
    end
  endtask

  task automatic t_parallel();
    base_mode = 1'b1;
    shift_code(4'd2);
    strobe_load();
    par_code = 4'd7;
    par_sel = 1'b1;
    wait_cyc(2);
    check_pair("R7 parallel 7", 1'b1, 7);
    par_code = 4'd9;
    wait_cyc(2);
    check_pair("R7 parallel 9", 1'b1, 9);
    shift_code(4'd4);
    strobe_load();
    check_pair("R7 serial load ignored", 1'b1, 9);
    par_code = 4'd12;
    wait_cyc(2);
    check_pair("R7 parallel illegal", 1'b1, 12);
    par_code = 4'd5;
    wait_cyc(1);
    par_sel = 1'b0;
    wait_cyc(3);
    check_pair("R8 hold after parallel", 1'b1, 5);
  endtask

  // R8: change lands one clock after the mode edge
  task automatic t_timing();
    base_mode = 1'b0;
    @(posedge clk);
    #1;
    check_pair("R8 one clock after mode", 1'b0, 5);
    wait_cyc(1);
    base_mode = 1'b1;
    wait_cyc(1);
    check_pair("R8 mode back", 1'b1, 5);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_mode = 1'b1; par_sel = 1'b0; par_code = 4'd0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_serial_order();
    t_base_table();
    t_remote_table();
    t_illegal();
    t_parallel();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule